// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus pins of a NOR-style flash memory and turns host write cycles into operations for a separate operation engine. A write is taken when chip enable and write strobe are low while output enable is high. The strobe is sampled on the system clock, and one low period of the strobe gives exactly one write event. The decoder follows a multi-cycle command grammar: two unlock writes at fixed addresses, then a command byte, and for erase a second unlock pair. The unlock addresses depend on whether the part is in byte or word addressing.

A recognised operation (program, chip erase, sector erase, erase suspend, erase resume) appears as a one-cycle start pulse. The pulse carries an operation code, the address and the data of the completing write. The decoder also keeps the read mode that the read path uses: normal array data, identifier data, or erase-suspended array data. In identifier mode it supplies the identifier byte for the current read address. An unlock-bypass mode shortens each program to two writes.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write event is taken only when ce_n=0, we_n=0 and oe_n=1 in the same sampled cycle, and a strobe held low for several cycles gives one event. A completing write raises op_start for exactly one cycle.
- R2: Unlock writes are data AAh then 55h in the low byte. In word mode (byte_mode=0) the addresses are 555h then 2AAh on addr[11:0]. In byte mode (byte_mode=1) they are AAAh then 555h.
- R3: Program: unlock, A0h at the first unlock address, then one write. That last write gives op_code=1 with op_addr and op_data taken from it, even when its data is F0h.
- R4: Chip erase: unlock, 80h at the first unlock address, unlock again, then 10h at the first unlock address. It gives op_code=2.
- R5: Sector erase: the same prefix as chip erase, then 30h at any address. It gives op_code=3 with op_addr set to that address.
- R6: A write that breaks the grammar drops the partial sequence and gives no operation. The next command must start again from the first unlock write.
- R7: Data F0h at any address, outside the data write of a program, gives no operation. It sets rd_mode to 0 (array), or to 2 (erase-suspend read) while an erase is suspended.
- R8: Unlock then 90h at the first unlock address sets rd_mode=1 (identifier). In that mode id_data follows addr[7:0]: 00h gives MFR_ID, 01h word / 02h byte gives DEV_ID, 02h word / 04h byte gives {7'b0, sect_prot}, and any other address gives 00h. In any other rd_mode, id_data is 00h.
- R9: Unlock then 20h at the first unlock address enters bypass. In bypass, A0h at any address followed by one more write gives a program, and other writes are ignored. 90h then 00h leaves bypass, and 90h followed by anything else stays in bypass.
- R10: B0h at any address, from idle, with erase_busy=1 and no erase already suspended, gives op_code=4 and sets rd_mode=2. Otherwise it gives no operation.
- R11: 30h at any address, from idle while an erase is suspended, gives op_code=5 and sets rd_mode=0. With no erase suspended it gives no operation.
- R12: While an erase is suspended, an erase sequence is dropped at its 80h write, but a program still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_mode | input | 1 | 1 = byte addressing, 0 = word addressing |
| addr | input | ADDR_W | Bus address |
| wdata | input | DATA_W | Bus write data |
| erase_busy | input | 1 | Engine reports an erase in progress |
| sect_prot | input | 1 | Protection status of the addressed sector |
| op_start | output | 1 | One-cycle operation start pulse |
| op_code | output | 3 | 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume |
| op_addr | output | ADDR_W | Address of the completing write |
| op_data | output | DATA_W | Data of the completing write |
| rd_mode | output | 2 | 0 array, 1 identifier, 2 erase-suspend read |
| id_data | output | 8 | Identifier byte for the current address |

## Verification
A grammar state that is wrong usually stays hidden until the host finishes a sequence. It then shows up as a missing or extra op_start two clock edges after the strobe of the completing write, or as an operation with the wrong code. A wrong suspend flag shows up in rd_mode at once after the next suspend, resume or reset write. It also shows up when a later resume or erase is accepted or refused. Identifier faults appear combinationally on id_data as soon as the address changes in identifier mode.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_PROG = 3'd1, OP_CHIP = 3'd2,
    OP_SECT = 3'd3, OP_SUSP = 3'd4, OP_RESUME = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    RD_ARRAY = 2'd0, RD_ID = 2'd1, RD_SUSP = 2'd2
  } rd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_UA, S_UB, S_PSETUP, S_E80, S_EUA, S_EUB,
    S_BYP, S_BPROG, S_BEXIT
  } seq_e;

  // Unlock key address: second=0 picks the first key, second=1 the second.
  function automatic logic [11:0] key_addr(input logic bm, input logic second);
    logic [11:0] w;
    w = second ? 12'h2AA : 12'h555;
    return bm ? {w[10:0], second} : w;
  endfunction

  // Identifier byte for a read offset.
  function automatic logic [7:0] id_value(input logic [7:0] a, input logic bm,
                                          input logic prot, input logic [7:0] mfr,
                                          input logic [7:0] dev);
    logic [7:0] idx;
    if (bm && a[0]) return 8'h00;
    idx = bm ? {1'b0, a[7:1]} : a;
    case (idx)
      8'd0:    return mfr;
      8'd1:    return dev;
      8'd2:    return {7'b0, prot};
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/fcd_wr_sampler.sv
module fcd_wr_sampler #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] ev_addr,
  output logic [DATA_W-1:0] ev_data,
  output logic              ev_bm
);
  logic act, act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act     <= 1'b0;
      act_q   <= 1'b0;
      ev_addr <= '0;
      ev_data <= '0;
      ev_bm   <= 1'b0;
    end else begin
      act   <= ~ce_n & ~we_n & oe_n;
      act_q <= act;
      if (~ce_n & ~we_n & oe_n & ~act) begin
        ev_addr <= addr;
        ev_data <= wdata;
        ev_bm   <= byte_mode;
      end
    end
  end

  assign wr_evt = act & ~act_q;
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [DATA_W-1:0] ev_data,
  input  logic              ev_bm,
  input  logic              erase_busy,
  output logic              op_start,
  output op_e               op_code,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output rd_e               rd_mode,
  output logic              data_phase
);
  seq_e st, n_st;
  rd_e  n_mode;
  logic susp, n_susp, fire;
  op_e  code;
  logic hit1, hit2;
  logic [7:0] d8;

  assign d8         = ev_data[7:0];
  assign hit1       = ev_addr[11:0] == key_addr(ev_bm, 1'b0);
  assign hit2       = ev_addr[11:0] == key_addr(ev_bm, 1'b1);
  assign data_phase = (st == S_PSETUP) || (st == S_BPROG);

  always_comb begin
    n_st   = st;
    n_mode = rd_mode;
    n_susp = susp;
    fire   = 1'b0;
    code   = OP_NONE;
    if (wr_evt) begin
      if (d8 == 8'hF0 && !data_phase) begin
        n_st   = S_IDLE;
        n_mode = susp ? RD_SUSP : RD_ARRAY;
      end else begin
        case (st)
          S_IDLE: begin
            if (d8 == 8'hAA && hit1) n_st = S_UA;
            else if (d8 == 8'hB0 && erase_busy && !susp) begin
              fire = 1'b1; code = OP_SUSP; n_susp = 1'b1; n_mode = RD_SUSP;
            end else if (d8 == 8'h30 && susp) begin
              fire = 1'b1; code = OP_RESUME; n_susp = 1'b0; n_mode = RD_ARRAY;
            end
          end
          S_UA: n_st = (d8 == 8'h55 && hit2) ? S_UB : S_IDLE;
          S_UB: begin
            n_st = S_IDLE;
            if (hit1) begin
              case (d8)
                8'hA0: n_st = S_PSETUP;
                8'h80: if (!susp) n_st = S_E80;
                8'h90: n_mode = RD_ID;
                8'h20: n_st = S_BYP;
                default: n_st = S_IDLE;
              endcase
            end
          end
          S_PSETUP: begin
            fire = 1'b1; code = OP_PROG; n_st = S_IDLE;
          end
          S_E80: n_st = (d8 == 8'hAA && hit1) ? S_EUA : S_IDLE;
          S_EUA: n_st = (d8 == 8'h55 && hit2) ? S_EUB : S_IDLE;
          S_EUB: begin
            n_st = S_IDLE;
            if (d8 == 8'h10 && hit1) begin
              fire = 1'b1; code = OP_CHIP;
            end else if (d8 == 8'h30) begin
              fire = 1'b1; code = OP_SECT;
            end
          end
          S_BYP: begin
            if (d8 == 8'hA0)      n_st = S_BPROG;
            else if (d8 == 8'h90) n_st = S_BEXIT;
          end
          S_BPROG: begin
            fire = 1'b1; code = OP_PROG; n_st = S_BYP;
          end
          S_BEXIT: n_st = (d8 == 8'h00) ? S_IDLE : S_BYP;
          default: n_st = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      susp     <= 1'b0;
      rd_mode  <= RD_ARRAY;
      op_start <= 1'b0;
      op_code  <= OP_NONE;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      st       <= n_st;
      susp     <= n_susp;
      rd_mode  <= n_mode;
      op_start <= fire;
      if (fire) begin
        op_code <= code;
        op_addr <= ev_addr;
        op_data <= ev_data;
      end
    end
  end
endmodule

// File: rtl/fcd_id_read.sv
module fcd_id_read
  import fcd_pkg::*;
#(
  parameter logic [7:0] MFR_ID = 8'h5A,
  parameter logic [7:0] DEV_ID = 8'hC3
) (
  input  rd_e        rd_mode,
  input  logic [7:0] rd_addr,
  input  logic       byte_mode,
  input  logic       sect_prot,
  output logic [7:0] id_data
);
  assign id_data = (rd_mode == RD_ID)
                 ? id_value(rd_addr, byte_mode, sect_prot, MFR_ID, DEV_ID)
                 : 8'h00;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int         ADDR_W = 20,
  parameter int         DATA_W = 16,
  parameter logic [7:0] MFR_ID = 8'h5A,
  parameter logic [7:0] DEV_ID = 8'hC3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              erase_busy,
  input  logic              sect_prot,
  output logic              op_start,
  output logic [2:0]        op_code,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [1:0]        rd_mode,
  output logic [7:0]        id_data
);
  logic              wr_evt, ev_bm, data_phase;
  logic [ADDR_W-1:0] ev_addr;
  logic [DATA_W-1:0] ev_data;
  logic [7:0]        ev_data8;
  op_e               code_i;
  rd_e               mode_i;

  fcd_wr_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .byte_mode(byte_mode), .addr(addr), .wdata(wdata),
    .wr_evt(wr_evt), .ev_addr(ev_addr), .ev_data(ev_data), .ev_bm(ev_bm)
  );

  fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .ev_addr(ev_addr),
    .ev_data(ev_data), .ev_bm(ev_bm), .erase_busy(erase_busy),
    .op_start(op_start), .op_code(code_i), .op_addr(op_addr),
    .op_data(op_data), .rd_mode(mode_i), .data_phase(data_phase)
  );

  fcd_id_read #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_id (
    .rd_mode(mode_i), .rd_addr(addr[7:0]), .byte_mode(byte_mode),
    .sect_prot(sect_prot), .id_data(id_data)
  );

  assign op_code  = code_i;
  assign rd_mode  = mode_i;
  assign ev_data8 = ev_data[7:0];
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       we_n,
  input logic       oe_n,
  input logic       erase_busy,
  input logic       op_start,
  input logic [2:0] op_code,
  input logic [1:0] rd_mode,
  input logic [7:0] id_data,
  input logic       wr_evt,
  input logic [7:0] ev_data8,
  input logic       data_phase
);
  assert_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);

  assert_from_evt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(wr_evt));

  assert_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> $past(!ce_n && !we_n && oe_n));

  assert_reset_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && ev_data8 == 8'hF0 && !data_phase) |=> (rd_mode != 2'd1 && !op_start));

  assert_id_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode != 2'd1) |-> (id_data == 8'h00));

  assert_suspend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_code == 3'd4) |-> ($past(erase_busy) && rd_mode == 2'd2));

  assert_resume_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_code == 3'd5) |-> (rd_mode == 2'd0 && $past(rd_mode) != 2'd0));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .erase_busy(erase_busy), .op_start(op_start), .op_code(op_code),
  .rd_mode(rd_mode), .id_data(id_data), .wr_evt(wr_evt),
  .ev_data8(ev_data8), .data_phase(data_phase)
);

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam logic [7:0] MFR = 8'h5A;
  localparam logic [7:0] DEV = 8'hC3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, byte_mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic erase_busy = 1'b0, sect_prot = 1'b0;
  logic op_start;
  logic [2:0] op_code;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic [1:0] rd_mode;
  logic [7:0] id_data;

  int n_run = 0, n_fail = 0, n_ops = 0, base = 0;
  logic [2:0] l_code;
  logic [AW-1:0] l_addr;
  logic [DW-1:0] l_data;

  always #4 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .MFR_ID(MFR), .DEV_ID(DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .byte_mode(byte_mode), .addr(addr), .wdata(wdata), .erase_busy(erase_busy),
    .sect_prot(sect_prot), .op_start(op_start), .op_code(op_code),
    .op_addr(op_addr), .op_data(op_data), .rd_mode(rd_mode), .id_data(id_data)
  );

  always @(negedge clk) if (rst_n && op_start) begin
    n_ops  <= n_ops + 1;
    l_code <= op_code;
    l_addr <= op_addr;
    l_data <= op_data;
  end

  function automatic logic [11:0] k1(input logic bm);
    return bm ? 12'hAAA : 12'h555;
  endfunction
  function automatic logic [11:0] k2(input logic bm);
    return bm ? 12'h555 : 12'h2AA;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic oe = 1'b1, input logic ce = 1'b0);
    @(negedge clk);
    addr = a; wdata = d; ce_n = ce; oe_n = oe; we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic unlock();
    wr({8'h00, k1(byte_mode)}, 16'h00AA);
    wr({8'h00, k2(byte_mode)}, 16'h0055);
  endtask

  task automatic cmd(input logic [7:0] c);
    unlock();
    wr({8'h00, k1(byte_mode)}, {8'h00, c});
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_op(input logic [2:0] c, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string req);
    chk(n_ops == base + 1, req, "op count", n_ops - base, 1);
    chk(l_code == c && l_addr == a && l_data == d, req, "op fields",
        {l_code, l_addr[11:0], l_data}, {c, a[11:0], d});
    base = n_ops;
  endtask

  task automatic chk_none(input string req);
    chk(n_ops == base, req, "no op", n_ops - base, 0);
    base = n_ops;
  endtask

  initial begin
    #(8ns * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R1, R8)
    chk(op_start == 1'b0, "R1", "op_start after reset", op_start, 0);
    chk(rd_mode == 2'd0, "R7", "rd_mode after reset", rd_mode, 0);
    chk(id_data == 8'h00, "R8", "id_data outside id mode", id_data, 0);

    // program sweep, both address modes (R2, R3)
    for (int bm = 0; bm < 2; bm++) begin
      byte_mode = bm[0];
      for (int k = 0; k < 5; k++) begin
        logic [AW-1:0] pa;
        logic [DW-1:0] pd;
        pa = AW'(20'h01230 + k * 20'h1D0B3);
        pd = DW'(16'hA5A5 ^ (k * 16'h1357));
        if (k == 4) pd = 16'h00F0;
        cmd(8'hA0);
        wr(pa, pd);
        chk_op(3'd1, pa, pd, "R3");
      end
    end

    // chip and sector erase (R4, R5)
    for (int bm = 0; bm < 2; bm++) begin
      byte_mode = bm[0];
      cmd(8'h80); unlock();
      wr({8'h00, k1(byte_mode)}, 16'h0010);
      chk_op(3'd2, {8'h00, k1(byte_mode)}, 16'h0010, "R4");
      cmd(8'h80); unlock();
      wr(20'hF3000 + AW'(bm), 16'h0030);
      chk_op(3'd3, 20'hF3000 + AW'(bm), 16'h0030, "R5");
    end

    // byte mode with word keys fails (R2)
    byte_mode = 1'b1;
    wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055); wr(20'h00555, 16'h00A0);
    wr(20'h00100, 16'h1234);
    chk_none("R2");
    byte_mode = 1'b0;

    // grammar breaks (R6)
    unlock(); wr(20'h00555, 16'h0077); wr(20'h00555, 16'h00A0); wr(20'h00200, 16'h4321);
    chk_none("R6");
    wr(20'h00555, 16'h00AA); wr(20'h002AB, 16'h0055); wr(20'h00555, 16'h00A0);
    wr(20'h00200, 16'h4321);
    chk_none("R6");

    // inhibited writes (R1)
    cmd(8'hA0);
    wr(20'h00300, 16'hBEEF, 1'b0, 1'b0);
    wr(20'h00300, 16'hBEEF, 1'b1, 1'b1);
    chk_none("R1");
    wr(20'h00304, 16'hCAFE);
    chk_op(3'd1, 20'h00304, 16'hCAFE, "R1");

    // autoselect (R8) and reset (R7)
    cmd(8'h90);
    chk(rd_mode == 2'd1, "R8", "rd_mode id", rd_mode, 1);
    for (int bm = 0; bm < 2; bm++) begin
      for (int a = 0; a < 6; a++) begin
        logic [7:0] ex;
        int idx;
        byte_mode = bm[0];
        addr = AW'(20'h40000 + a);
        sect_prot = a[0] ^ bm[0];
        idx = bm ? ((a % 2 == 1) ? 99 : a / 2) : a;
        ex = (idx == 0) ? MFR : (idx == 1) ? DEV : (idx == 2) ? {7'b0, sect_prot} : 8'h00;
        @(negedge clk);
        chk(id_data == ex, "R8", "id byte", id_data, ex);
      end
    end
    byte_mode = 1'b0; sect_prot = 1'b0;
    wr(20'h7777F, 16'h00F0);
    chk(rd_mode == 2'd0, "R7", "rd_mode after reset cmd", rd_mode, 0);
    addr = '0; @(negedge clk);
    chk(id_data == 8'h00, "R8", "id quiet after exit", id_data, 0);
    chk_none("R7");

    // unlock bypass (R9)
    cmd(8'h20);
    for (int k = 0; k < 3; k++) begin
      wr(20'h00123, 16'h00A0);
      wr(AW'(20'h08000 + k * 2), DW'(16'h1111 * (k + 1)));
      chk_op(3'd1, AW'(20'h08000 + k * 2), DW'(16'h1111 * (k + 1)), "R9");
    end
    wr(20'h00000, 16'h0090); wr(20'h00000, 16'h0077);
    wr(20'h00000, 16'h00A0); wr(20'h09000, 16'h5555);
    chk_op(3'd1, 20'h09000, 16'h5555, "R9");
    wr(20'h00000, 16'h0090); wr(20'h00000, 16'h0000);
    wr(20'h00000, 16'h00A0); wr(20'h09002, 16'h6666);
    chk_none("R9");

    // suspend (R10)
    wr(20'h00010, 16'h00B0);
    chk_none("R10");
    chk(rd_mode == 2'd0, "R10", "rd_mode without erase", rd_mode, 0);
    erase_busy = 1'b1;
    wr(20'h00010, 16'h00B0);
    chk_op(3'd4, 20'h00010, 16'h00B0, "R10");
    chk(rd_mode == 2'd2, "R10", "rd_mode suspended", rd_mode, 2);
    wr(20'h00010, 16'h00B0);
    chk_none("R10");

    // suspended: program ok, erase dropped (R12), reset keeps suspend read (R7)
    cmd(8'hA0); wr(20'h0A000, 16'h7E7E);
    chk_op(3'd1, 20'h0A000, 16'h7E7E, "R12");
    cmd(8'h80); unlock(); wr(20'hE0000, 16'h0030);
    chk_none("R12");
    cmd(8'h90);
    chk(rd_mode == 2'd1, "R8", "id while suspended", rd_mode, 1);
    wr(20'h00000, 16'h00F0);
    chk(rd_mode == 2'd2, "R7", "reset while suspended", rd_mode, 2);

    // resume (R11)
    wr(20'h12345, 16'h0030);
    chk_op(3'd5, 20'h12345, 16'h0030, "R11");
    chk(rd_mode == 2'd0, "R11", "rd_mode after resume", rd_mode, 0);
    wr(20'h12345, 16'h0030);
    chk_none("R11");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule